// File: doc/BRIEF.md
# Asymmetric Digital Lock Detector

This block judges whether a phase-locked loop has settled. A phase comparator outside the block delivers, once per comparison, a strobe and a flag that says whether the phase error stayed inside one reference period. The detector keeps a lock decision with hysteresis. A long unbroken run of in-window comparisons is needed to declare lock. A shorter unbroken run of out-of-window comparisons is enough to withdraw it. One select input chooses between two pairs of run lengths.

Every frequency write forces the decision back to unlocked and restarts the run. A mode input lets the raw phase-comparison signal drive the lock output in place of the counted decision. A mute output tells the local-oscillator path to silence itself while the counted decision is unlocked and muting is enabled.

Top module: `phase_lock_judge`

## Requirements
- R1: After reset, and in the cycle after any clock edge that samples `freqWrite` high, the counted decision is unlocked and the run count is zero. `freqWrite` takes priority over a comparison strobed in the same cycle.
- R2: While unlocked, the decision becomes locked on the comparison that makes the run of consecutive in-window comparisons exceed the lock threshold. The threshold is 15 with `longRun`=0 and 31 with `longRun`=1, so lock comes on the 16th or the 32nd good comparison.
- R3: While locked, the decision becomes unlocked on the comparison that makes the run of consecutive out-of-window comparisons exceed the unlock threshold. The threshold is 3 with `longRun`=0 and 7 with `longRun`=1, so unlock comes on the 4th or the 8th bad comparison.
- R4: A strobed comparison of the opposite kind to the one being counted (out-of-window while unlocked, in-window while locked) sets the run count back to zero.
- R5: Only cycles with `cmpValid`=1 count. Cycles with `cmpValid`=0 neither advance the run nor break it.
- R6: A change of `longRun` clears the run count and leaves the current lock decision unchanged. A comparison strobed in the cycle of the change is discarded.
- R7: With `rawMode`=1, `lockOut` equals `rawPhase`. The counted decision keeps tracking comparisons underneath and reappears on `lockOut` when `rawMode` returns to 0.
- R8: `muteOut` is 1 exactly when `muteEn`=1 and the counted decision is unlocked, whatever the value of `rawMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freqWrite | input | 1 | One-cycle pulse on a frequency setup; forces unlocked |
| cmpValid | input | 1 | Strobe marking a cycle that carries a comparison result |
| inWindow | input | 1 | 1 = phase error below one reference period |
| rawPhase | input | 1 | Raw phase-comparison signal for bypass mode |
| longRun | input | 1 | 0 = thresholds 15/3, 1 = thresholds 31/7 |
| rawMode | input | 1 | 1 = `lockOut` follows `rawPhase` |
| muteEn | input | 1 | Enables muting of the local output while unlocked |
| lockOut | output | 1 | Lock indication (counted decision or raw signal) |
| muteOut | output | 1 | Mute request for the local output |

## Verification
For both select settings the bench sweeps the length of a good run from zero to two past the lock threshold. It also sweeps the length of a bad run from a locked start. These sweeps pin down the exact comparison on which each transition happens and separate an off-by-one at either threshold. Runs broken by a single opposite comparison tell a counter that resets apart from one that only pauses. Runs interleaved with idle cycles show that strobes, not clock edges, are counted. Select toggles just short of a threshold, raw-mode phases, a frequency write that collides with a good comparison, and every combination of mute enable with lock state cover the remaining controls.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  // Strobes from the control to the run counter
  typedef struct packed {
    logic clr;   // restart the run at zero
    logic inc;   // one more qualifying comparison
  } runCtl_t;
endpackage

// File: rtl/lockdet_run_counter.sv
module lockdet_run_counter
  import lockdet_pkg::*;
#(
  parameter int LOCK_SHORT   = 15,
  parameter int UNLOCK_SHORT = 3,
  parameter int LOCK_LONG    = 31,
  parameter int UNLOCK_LONG  = 7
) (
  input  logic    clk,
  input  logic    rst_n,
  input  runCtl_t ctl,
  input  logic    locked,
  input  logic    longRun,
  output logic    runDone
);
  localparam int MAX_A   = (LOCK_SHORT > LOCK_LONG) ? LOCK_SHORT : LOCK_LONG;
  localparam int MAX_B   = (UNLOCK_SHORT > UNLOCK_LONG) ? UNLOCK_SHORT : UNLOCK_LONG;
  localparam int MAX_THR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_THR + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] thr;

  // Threshold depends on the direction being counted and on the select
  always_comb begin
    if (locked) thr = longRun ? CNT_W'(UNLOCK_LONG) : CNT_W'(UNLOCK_SHORT);
    else        thr = longRun ? CNT_W'(LOCK_LONG)   : CNT_W'(LOCK_SHORT);
  end

  // This comparison takes the run past the threshold when the count already equals it
  assign runDone = (runCnt >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            runCnt <= '0;
    else if (ctl.clr)                      runCnt <= '0;
    else if (ctl.inc && runCnt != CNT_MAX) runCnt <= runCnt + CNT_W'(1);
  end

  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> (runCnt == '0));

  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.inc && !ctl.clr && runCnt != CNT_MAX) |=> (runCnt == $past(runCnt) + CNT_W'(1)));

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.inc && !ctl.clr) |=> $stable(runCnt));
endmodule

// File: rtl/lockdet_control.sv
module lockdet_control
  import lockdet_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    freqWrite,
  input  logic    cmpValid,
  input  logic    inWindow,
  input  logic    longRun,
  input  logic    muteEn,
  input  logic    runDone,
  output runCtl_t ctl,
  output logic    lockState,
  output logic    muteOut
);
  logic selPrev;
  logic selChange;
  logic qualify;
  logic flip;

  assign selChange = (longRun != selPrev);
  // A qualifying comparison pushes toward the opposite state
  assign qualify   = cmpValid && (lockState ? !inWindow : inWindow);
  assign flip      = qualify && runDone && !freqWrite && !selChange;

  always_comb begin
    ctl.inc = qualify && !freqWrite && !selChange;
    ctl.clr = freqWrite || selChange || (cmpValid && !qualify) || flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockState <= 1'b0;
      selPrev   <= 1'b0;
    end else begin
      selPrev <= longRun;
      if (freqWrite) lockState <= 1'b0;
      else if (flip) lockState <= !lockState;
    end
  end

  assign muteOut = muteEn && !lockState;

  p_freq_unlock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    freqWrite |=> !lockState);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmpValid && !freqWrite) |=> $stable(lockState));

  p_sel_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (selChange && !freqWrite) |=> $stable(lockState));

  p_rise_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockState) |-> $past(cmpValid && inWindow));

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lockState) |-> $past(freqWrite || (cmpValid && !inWindow)));
endmodule

// File: rtl/phase_lock_judge.sv
module phase_lock_judge
  import lockdet_pkg::*;
#(
  parameter int LOCK_SHORT   = 15,
  parameter int UNLOCK_SHORT = 3,
  parameter int LOCK_LONG    = 31,
  parameter int UNLOCK_LONG  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freqWrite,
  input  logic cmpValid,
  input  logic inWindow,
  input  logic rawPhase,
  input  logic longRun,
  input  logic rawMode,
  input  logic muteEn,
  output logic lockOut,
  output logic muteOut
);
  runCtl_t ctl;
  logic    runDone;
  logic    lockState;

  lockdet_run_counter #(
    .LOCK_SHORT  (LOCK_SHORT),
    .UNLOCK_SHORT(UNLOCK_SHORT),
    .LOCK_LONG   (LOCK_LONG),
    .UNLOCK_LONG (UNLOCK_LONG)
  ) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .locked (lockState),
    .longRun(longRun),
    .runDone(runDone)
  );

  lockdet_control u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .freqWrite(freqWrite),
    .cmpValid (cmpValid),
    .inWindow (inWindow),
    .longRun  (longRun),
    .muteEn   (muteEn),
    .runDone  (runDone),
    .ctl      (ctl),
    .lockState(lockState),
    .muteOut  (muteOut)
  );

  assign lockOut = rawMode ? rawPhase : lockState;

  p_mute_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rawMode && lockOut) |-> !muteOut);
endmodule

// File: tb/test_phase_lock_judge.sv
module test_phase_lock_judge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic freqWrite = 1'b0, cmpValid = 1'b0, inWindow = 1'b0, rawPhase = 1'b0;
  logic longRun = 1'b0, rawMode = 1'b0, muteEn = 1'b0;
  logic lockOut, muteOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_lock_judge i_phase_lock_judge (
    .clk(clk), .rst_n(rst_n), .freqWrite(freqWrite), .cmpValid(cmpValid),
    .inWindow(inWindow), .rawPhase(rawPhase), .longRun(longRun),
    .rawMode(rawMode), .muteEn(muteEn), .lockOut(lockOut), .muteOut(muteOut)
  );

  task automatic check(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, actual, expected);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic freq();
    @(negedge clk); freqWrite = 1'b1;
    @(negedge clk); freqWrite = 1'b0;
  endtask

  task automatic comp(input logic good);
    @(negedge clk); cmpValid = 1'b1; inWindow = good;
    @(negedge clk); cmpValid = 1'b0;
  endtask

  task automatic comps(input int n, input logic good);
    for (int i = 0; i < n; i++) comp(good);
  endtask

  task automatic setSel(input logic s);
    @(negedge clk); longRun = s;
    @(negedge clk);
  endtask

  function automatic int lockThr(input logic s);
    return s ? 31 : 15;
  endfunction

  function automatic int unlockThr(input logic s);
    return s ? 7 : 3;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(lockOut, 1'b0, "R1 reset lock");
    muteEn = 1'b1; #1;
    check(muteOut, 1'b1, "R8 reset mute");
    muteEn = 1'b0;

    for (int s = 0; s < 2; s++) begin
      setSel(s[0]);
      // R2: lock run sweep
      for (int k = 0; k <= lockThr(s[0]) + 2; k++) begin
        freq();
        comps(k, 1'b1);
        check(lockOut, (k > lockThr(s[0])), $sformatf("R2 sel=%0d run=%0d", s, k));
      end
      // R3: unlock run sweep
      for (int k = 0; k <= unlockThr(s[0]) + 2; k++) begin
        freq();
        comps(lockThr(s[0]) + 1, 1'b1);
        check(lockOut, 1'b1, $sformatf("R3 pre-lock sel=%0d", s));
        comps(k, 1'b0);
        check(lockOut, !(k > unlockThr(s[0])), $sformatf("R3 sel=%0d run=%0d", s, k));
      end
      // R4: broken runs
      freq();
      comps(lockThr(s[0]), 1'b1);
      comp(1'b0);
      comps(lockThr(s[0]), 1'b1);
      check(lockOut, 1'b0, $sformatf("R4 broken good run sel=%0d", s));
      comp(1'b1);
      check(lockOut, 1'b1, $sformatf("R4 good run completes sel=%0d", s));
      comps(unlockThr(s[0]), 1'b0);
      comp(1'b1);
      comps(unlockThr(s[0]), 1'b0);
      check(lockOut, 1'b1, $sformatf("R4 broken bad run sel=%0d", s));
      comp(1'b0);
      check(lockOut, 1'b0, $sformatf("R4 bad run completes sel=%0d", s));
      // R5: idle cycles between strobes
      freq();
      for (int i = 0; i < lockThr(s[0]); i++) begin comp(1'b1); idle(); idle(); end
      check(lockOut, 1'b0, $sformatf("R5 idle interleave short sel=%0d", s));
      comp(1'b1);
      check(lockOut, 1'b1, $sformatf("R5 idle interleave lock sel=%0d", s));
      inWindow = 1'b0;
      repeat (20) idle();
      check(lockOut, 1'b1, $sformatf("R5 no strobe no unlock sel=%0d", s));
    end

    // R6: select change clears the run
    setSel(1'b0);
    freq();
    comps(15, 1'b1);
    setSel(1'b1);
    setSel(1'b0);
    comps(15, 1'b1);
    check(lockOut, 1'b0, "R6 run cleared by select");
    comp(1'b1);
    check(lockOut, 1'b1, "R6 lock after fresh run");
    setSel(1'b1);
    check(lockOut, 1'b1, "R6 lock kept across select");
    comps(7, 1'b0);
    check(lockOut, 1'b1, "R6 new unlock threshold 7");
    comp(1'b0);
    check(lockOut, 0, "R6 unlock on 8th");
    // R6: comparison in the select-change cycle is discarded
    setSel(1'b0);
    freq();
    comps(15, 1'b1);
    @(negedge clk); longRun = 1'b1; cmpValid = 1'b1; inWindow = 1'b1;
    @(negedge clk); cmpValid = 1'b0;
    check(lockOut, 1'b0, "R6 strobe at select change discarded");
    comps(31, 1'b1);
    check(lockOut, 1'b0, "R6 thirty-one after change");
    comp(1'b1);
    check(lockOut, 1'b1, "R6 thirty-second locks");

    // R1: freqWrite beats a simultaneous good comparison
    @(negedge clk); freqWrite = 1'b1; cmpValid = 1'b1; inWindow = 1'b1;
    @(negedge clk); freqWrite = 1'b0; cmpValid = 1'b0;
    check(lockOut, 1'b0, "R1 freq write forces unlock");
    comps(31, 1'b1);
    check(lockOut, 1'b0, "R1 run restarted by freq write");

    // R7: raw bypass
    setSel(1'b0);
    freq();
    rawMode = 1'b1;
    rawPhase = 1'b1; #1; check(lockOut, 1'b1, "R7 raw high");
    rawPhase = 1'b0; #1; check(lockOut, 1'b0, "R7 raw low");
    comps(16, 1'b1);
    check(lockOut, 1'b0, "R7 raw hides counted lock");
    muteEn = 1'b1; #1;
    check(muteOut, 1'b0, "R8 mute follows counted lock in raw mode");
    rawMode = 1'b0; #1;
    check(lockOut, 1'b1, "R7 counted lock reappears");

    // R8: mute combinations
    check(muteOut, 1'b0, "R8 locked no mute");
    comps(4, 1'b0);
    check(muteOut, 1'b1, "R8 unlocked mute");
    muteEn = 1'b0; #1;
    check(muteOut, 1'b0, "R8 mute disabled");

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule